// File: doc/BRIEF.md
# Transmit Frame Buffer and Send Controller

This block collects an outgoing link frame written one byte at a time by a port controller, and hands it to the link partner logic when the controller writes the transmit command. An access to the buffer starts with a count byte that arms a remaining-byte counter. Every later data byte lands at the next free slot of the frame store. The write index is not cleared by a new count byte, so a frame may be built from several accesses. A transmit command latches the frame length (the current write index), the frame type and the retry count. It issues a single-cycle send request and rewinds the index for the next frame.

The partner returns a status code that the block turns into sticky alert flags for success, discard or failure. Sends of the two reset types bypass the short-frame check and always raise both the success and the failure flags. A hard-reset send also pulses a cleanup strobe, which tells the receive side to stop delivery, drop queued frames and reload its interrupt masks. Malformed accesses pulse an interface-error strobe and leave the frame state unchanged.

Top module: `txframe_ctrl`

## Requirements
- R1: After reset, send_req, if_err, hrst_cleanup and all three alert flags are 0 and the write index is 0.
- R2: On the buffer select (wr_sel=1), the byte at wr_pos=0 loads the remaining count. Each byte at wr_pos>0 is stored at the current write index, which then increments while the count decrements. A later count byte does not rewind the index. After a send, rd_idx=i returns the byte stored at slot i.
- R3: A data byte that arrives while the remaining count is 0 pulses if_err in the next cycle and is not stored, so the frame length does not change.
- R4: A transmit access (wr_sel=2) of one byte at wr_pos=0 with wr_last set produces send_req for exactly one cycle, in the next cycle. In that cycle send_len equals the write index, send_type equals bits [2:0] of the byte and send_retry equals bits [5:4]. The write index is then 0.
- R5: Types 0 to 4 form the normal frame family. For these types, a length below 2 is rejected: if_err pulses, send_req stays 0, and the write index still returns to 0. Type 7 has no minimum length.
- R6: stat_valid with stat_code 0, 1 or 2 sets alert_ok, alert_disc or alert_fail respectively in the next cycle, and code 3 sets nothing. A flag stays set until its alert_clr bit is written (bit 0 ok, bit 1 disc, bit 2 fail). A set in the same cycle as a clear wins.
- R7: A send of type 5 (hard reset) or type 6 (cable reset) is never length-checked. It sets both alert_ok and alert_fail in the same cycle as its send_req.
- R8: hrst_cleanup pulses with the send_req of a type 5 send and never otherwise.
- R9: A command access (wr_sel=3) of byte CMD_FLUSH_TX (default 8'hB1) at wr_pos=0 zeroes the write index. Other command codes leave it unchanged.
- R10: A transmit access whose last byte is at wr_pos other than 0 pulses if_err, sends nothing and leaves the write index unchanged.
- R11: A data byte written while the index equals DEPTH pulses if_err and is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 2 | Target: 0 none, 1 buffer, 2 transmit, 3 command |
| wr_pos | input | 8 | Byte position within the current access |
| wr_last | input | 1 | Last byte of the access |
| wr_data | input | 8 | Write byte |
| rd_idx | input | IDX_W | Frame store read slot for the partner |
| rd_data | output | 8 | Byte at rd_idx (0 past DEPTH) |
| stat_valid | input | 1 | Partner status strobe |
| stat_code | input | 2 | 0 success, 1 discarded, 2 failed, 3 none |
| alert_clr | input | 3 | Write-one-to-clear for ok, disc, fail |
| send_req | output | 1 | One-cycle send request |
| send_type | output | 3 | Frame type of the request |
| send_retry | output | 2 | Retry count of the request |
| send_len | output | IDX_W | Frame length in bytes |
| alert_ok | output | 1 | Sticky transmit-success flag |
| alert_disc | output | 1 | Sticky transmit-discarded flag |
| alert_fail | output | 1 | Sticky transmit-failed flag |
| if_err | output | 1 | One-cycle interface error pulse |
| hrst_cleanup | output | 1 | Receive flush and mask reload strobe |

## Verification
The main sweep loads every frame length from 0 to DEPTH and sends it as each of the eight types, with the retry count varied as well. This separates the short-frame rejection of the normal family from the unchecked type 7 and the two reset types. It also shows that only type 5 raises the cleanup strobe, and it reads the store back to confirm byte order. Directed patterns cover the remaining corner cases: overrun of the count, overrun of the store, accumulation across two count bytes, the flush command against an unrelated command, a two-byte transmit access, all four status codes, and a clear colliding with a set.

// File: rtl/txframe_pkg.sv
package txframe_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_BUF  = 2'd1,
        SEL_XMIT = 2'd2,
        SEL_CMD  = 2'd3
    } wsel_e;

    typedef enum logic [1:0] {
        ST_OK   = 2'd0,
        ST_DISC = 2'd1,
        ST_FAIL = 2'd2,
        ST_NONE = 2'd3
    } stat_e;

    localparam logic [2:0] TYPE_HRST   = 3'd5;
    localparam logic [2:0] TYPE_CRST   = 3'd6;
    localparam int         NORMAL_TYPES = 5;
    localparam int         MIN_NORMAL_LEN = 2;

    // alert flag bit positions
    localparam int AL_OK   = 0;
    localparam int AL_DISC = 1;
    localparam int AL_FAIL = 2;

endpackage

// File: rtl/txframe_type_class.sv
module txframe_type_class
    import txframe_pkg::*;
(
    input  logic [2:0] ftype,
    output logic       is_normal,
    output logic       is_hrst,
    output logic       is_crst
);
    always_comb begin
        is_normal = (int'(ftype) < NORMAL_TYPES);
        is_hrst   = (ftype == TYPE_HRST);
        is_crst   = (ftype == TYPE_CRST);
    end
endmodule

// File: rtl/txframe_store.sv
module txframe_store #(
    parameter int DEPTH = 32,
    parameter int IDX_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) begin
            slot_q[waddr[AW-1:0]] <= wdata;
        end
    end

    always_comb begin
        if (int'(raddr) < DEPTH) begin
            rdata = slot_q[raddr[AW-1:0]];
        end else begin
            rdata = 8'h00;
        end
    end
endmodule

// File: rtl/txframe_alerts.sv
module txframe_alerts
    import txframe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stat_valid,
    input  logic [1:0] stat_code,
    input  logic       both_set,
    input  logic [2:0] clr,
    output logic [2:0] flags
);
    typedef struct packed {
        logic [2:0] flags;
    } al_state_t;

    al_state_t al_d, al_q;
    logic [2:0] set_v;

    always_comb begin
        set_v = '0;
        if (stat_valid) begin
            unique case (stat_e'(stat_code))
                ST_OK:   set_v[AL_OK]   = 1'b1;
                ST_DISC: set_v[AL_DISC] = 1'b1;
                ST_FAIL: set_v[AL_FAIL] = 1'b1;
                default: set_v = '0;
            endcase
        end
        if (both_set) begin
            set_v[AL_OK]   = 1'b1;
            set_v[AL_FAIL] = 1'b1;
        end
        al_d.flags = (al_q.flags & ~clr) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            al_q <= '0;
        end else begin
            al_q <= al_d;
        end
    end

    assign flags = al_q.flags;
endmodule

// File: rtl/txframe_ctrl.sv
module txframe_ctrl
    import txframe_pkg::*;
#(
    parameter int         DEPTH        = 32,
    parameter logic [7:0] CMD_FLUSH_TX = 8'hB1,
    parameter int         IDX_W        = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [7:0]       wr_pos,
    input  logic             wr_last,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    input  logic             stat_valid,
    input  logic [1:0]       stat_code,
    input  logic [2:0]       alert_clr,
    output logic             send_req,
    output logic [2:0]       send_type,
    output logic [1:0]       send_retry,
    output logic [IDX_W-1:0] send_len,
    output logic             alert_ok,
    output logic             alert_disc,
    output logic             alert_fail,
    output logic             if_err,
    output logic             hrst_cleanup
);
    localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(DEPTH);
    localparam logic [IDX_W-1:0] IDX_MIN  = IDX_W'(MIN_NORMAL_LEN);

    typedef struct packed {
        logic [7:0]       rem;
        logic [IDX_W-1:0] idx;
        logic             send_req;
        logic [2:0]       send_type;
        logic [1:0]       send_retry;
        logic [IDX_W-1:0] send_len;
        logic             err;
        logic             hrst;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       mem_we;
    logic       both_set;
    logic       ty_normal, ty_hrst, ty_crst;
    logic [2:0] flags;
    wsel_e      sel;

    assign sel = wsel_e'(wr_sel);

    txframe_type_class u_class (
        .ftype     (wr_data[2:0]),
        .is_normal (ty_normal),
        .is_hrst   (ty_hrst),
        .is_crst   (ty_crst)
    );

    txframe_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (st_q.idx),
        .wdata (wr_data),
        .raddr (rd_idx),
        .rdata (rd_data)
    );

    always_comb begin
        st_d          = st_q;
        st_d.send_req = 1'b0;
        st_d.err      = 1'b0;
        st_d.hrst     = 1'b0;
        mem_we        = 1'b0;
        both_set      = 1'b0;
        if (wr_en) begin
            unique case (sel)
                SEL_BUF: begin
                    if (wr_pos == 8'd0) begin
                        st_d.rem = wr_data;
                    end else if ((st_q.rem == 8'd0) || (st_q.idx == IDX_FULL)) begin
                        st_d.err = 1'b1;
                    end else begin
                        mem_we   = 1'b1;
                        st_d.idx = st_q.idx + 1'b1;
                        st_d.rem = st_q.rem - 8'd1;
                    end
                end
                SEL_XMIT: begin
                    if (wr_last) begin
                        if (wr_pos != 8'd0) begin
                            st_d.err = 1'b1;
                        end else begin
                            st_d.idx = '0;
                            if (ty_normal && (st_q.idx < IDX_MIN)) begin
                                st_d.err = 1'b1;
                            end else begin
                                st_d.send_req   = 1'b1;
                                st_d.send_type  = wr_data[2:0];
                                st_d.send_retry = wr_data[5:4];
                                st_d.send_len   = st_q.idx;
                                st_d.hrst       = ty_hrst;
                                both_set        = ty_hrst | ty_crst;
                            end
                        end
                    end
                end
                SEL_CMD: begin
                    if ((wr_pos == 8'd0) && (wr_data == CMD_FLUSH_TX)) begin
                        st_d.idx = '0;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    txframe_alerts u_alerts (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_valid (stat_valid),
        .stat_code  (stat_code),
        .both_set   (both_set),
        .clr        (alert_clr),
        .flags      (flags)
    );

    assign send_req     = st_q.send_req;
    assign send_type    = st_q.send_type;
    assign send_retry   = st_q.send_retry;
    assign send_len     = st_q.send_len;
    assign if_err       = st_q.err;
    assign hrst_cleanup = st_q.hrst;
    assign alert_ok     = flags[AL_OK];
    assign alert_disc   = flags[AL_DISC];
    assign alert_fail   = flags[AL_FAIL];
endmodule

// File: rtl/txframe_ctrl_chk.sv
module txframe_ctrl_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [7:0]       wr_pos,
    input logic             wr_last,
    input logic             stat_valid,
    input logic [1:0]       stat_code,
    input logic             send_req,
    input logic [2:0]       send_type,
    input logic [IDX_W-1:0] send_len,
    input logic             alert_ok,
    input logic             alert_disc,
    input logic             alert_fail,
    input logic             if_err,
    input logic             hrst_cleanup
);
    // R4: a request only follows a single-byte transmit access
    a_r4_send_cause: assert property (@(posedge clk) disable iff (!rst_n)
        send_req |-> $past(wr_en && wr_sel == 2'd2 && wr_last && wr_pos == 8'd0));

    // R5: normal-family frames that go out are at least two bytes long
    a_r5_min_len: assert property (@(posedge clk) disable iff (!rst_n)
        (send_req && send_type < 3'd5) |-> (send_len >= IDX_W'(2)));

    // R7: reset-type sends carry both outcome flags
    a_r7_both_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (send_req && (send_type == 3'd5 || send_type == 3'd6)) |-> (alert_ok && alert_fail));

    // R8: cleanup strobe only with a hard-reset send
    a_r8_cleanup_with_hrst: assert property (@(posedge clk) disable iff (!rst_n)
        hrst_cleanup |-> (send_req && send_type == 3'd5));

    // R6: discard flag only rises on a discard status
    a_r6_disc_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_disc) |-> $past(stat_valid && stat_code == 2'd1));

    // R3: an error never appears without a write one cycle earlier
    a_r3_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        if_err |-> $past(wr_en));

    // R10: a rejected command never sends
    a_r10_err_excl_send: assert property (@(posedge clk) disable iff (!rst_n)
        if_err |-> !send_req);
endmodule

bind txframe_ctrl txframe_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_pos       (wr_pos),
    .wr_last      (wr_last),
    .stat_valid   (stat_valid),
    .stat_code    (stat_code),
    .send_req     (send_req),
    .send_type    (send_type),
    .send_len     (send_len),
    .alert_ok     (alert_ok),
    .alert_disc   (alert_disc),
    .alert_fail   (alert_fail),
    .if_err       (if_err),
    .hrst_cleanup (hrst_cleanup)
);

// File: tb/txframe_ctrl_tb_top.sv
`timescale 1ns/1ps
module txframe_ctrl_tb_top;
    localparam int DEPTH = 8;
    localparam int IDX_W = $clog2(DEPTH + 1);
    localparam logic [7:0] FLUSH = 8'hB1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_pos = 8'd0;
    logic wr_last = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [7:0] rd_data;
    logic stat_valid = 1'b0;
    logic [1:0] stat_code = 2'd0;
    logic [2:0] alert_clr = 3'd0;
    logic send_req;
    logic [2:0] send_type;
    logic [1:0] send_retry;
    logic [IDX_W-1:0] send_len;
    logic alert_ok, alert_disc, alert_fail, if_err, hrst_cleanup;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    txframe_ctrl #(.DEPTH(DEPTH), .CMD_FLUSH_TX(FLUSH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_pos(wr_pos),
        .wr_last(wr_last), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .stat_valid(stat_valid), .stat_code(stat_code), .alert_clr(alert_clr),
        .send_req(send_req), .send_type(send_type), .send_retry(send_retry),
        .send_len(send_len), .alert_ok(alert_ok), .alert_disc(alert_disc),
        .alert_fail(alert_fail), .if_err(if_err), .hrst_cleanup(hrst_cleanup)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // one byte write; returns at the falling edge after the capturing edge
    task automatic put(input logic [1:0] s, input logic [7:0] p, input logic [7:0] d, input logic l);
        wr_en = 1'b1; wr_sel = s; wr_pos = p; wr_data = d; wr_last = l;
        @(negedge clk);
        wr_en = 1'b0; wr_last = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic stat(input logic [1:0] c, input logic [2:0] clr);
        stat_valid = 1'b1; stat_code = c; alert_clr = clr;
        @(negedge clk);
        stat_valid = 1'b0; alert_clr = 3'd0;
    endtask

    function automatic logic [7:0] dval(input int seed, input int i);
        return 8'(seed * 13 + i * 7 + 1);
    endfunction

    task automatic load(input int n, input int seed);
        put(2'd1, 8'd0, 8'(n), n == 0);
        for (int i = 0; i < n; i++) put(2'd1, 8'(i + 1), dval(seed, i), i == n - 1);
    endtask

    int flags_v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(send_req == 0 && if_err == 0 && hrst_cleanup == 0, "R1 strobes after reset",
            int'({send_req, if_err, hrst_cleanup}), 0);
        chk({alert_ok, alert_disc, alert_fail} == 3'b000, "R1 alerts after reset",
            int'({alert_ok, alert_disc, alert_fail}), 0);
        put(2'd2, 8'd0, 8'h00, 1'b1);
        chk(if_err == 1 && send_req == 0, "R1 index zero after reset (R5 reject)", int'(if_err), 1);

        // R4 R5 R7 R8 R2: sweep length x type
        for (int n = 0; n <= DEPTH; n++) begin
            for (int t = 0; t < 8; t++) begin
                automatic int r = (n + t) % 4;
                automatic bit rej = (t < 5) && (n < 2);
                automatic bit rst_t = (t == 5) || (t == 6);
                load(n, n * 8 + t);
                put(2'd2, 8'd0, 8'((r << 4) | t), 1'b1);
                if (rej) begin
                    chk(if_err == 1 && send_req == 0, "R5 short normal frame rejected",
                        int'({if_err, send_req}), 2);
                end else begin
                    chk(send_req == 1 && if_err == 0, "R4 send request pulse", int'(send_req), 1);
                    chk(int'(send_len) == n, "R4 send length", int'(send_len), n);
                    chk(int'(send_type) == t && int'(send_retry) == r, "R4 type and retry",
                        int'({send_type, send_retry}), (t << 2) | r);
                    chk(alert_ok == rst_t && alert_fail == rst_t && alert_disc == 0,
                        "R7 reset-type flags", int'({alert_ok, alert_disc, alert_fail}),
                        rst_t ? 5 : 0);
                    chk(hrst_cleanup == (t == 5), "R8 cleanup strobe", int'(hrst_cleanup),
                        int'(t == 5));
                    for (int i = 0; i < n; i++) begin
                        rd_idx = IDX_W'(i);
                        #0.5;
                        chk(rd_data == dval(n * 8 + t, i), "R2 stored byte", int'(rd_data),
                            int'(dval(n * 8 + t, i)));
                    end
                end
                idle();
                chk(send_req == 0 && hrst_cleanup == 0, "R4 pulse lasts one cycle",
                    int'({send_req, hrst_cleanup}), 0);
                stat(2'd3, 3'b111);
            end
        end

        // R2: index carries across count bytes
        load(2, 1);
        load(1, 2);
        put(2'd2, 8'd0, 8'd0, 1'b1);
        chk(send_req == 1 && int'(send_len) == 3, "R2 accumulate across count bytes",
            int'(send_len), 3);
        rd_idx = IDX_W'(2); #0.5;
        chk(rd_data == dval(2, 0), "R2 third slot", int'(rd_data), int'(dval(2, 0)));

        // R3: remaining count exhausted
        put(2'd1, 8'd0, 8'd2, 1'b0);
        put(2'd1, 8'd1, 8'h11, 1'b0);
        put(2'd1, 8'd2, 8'h22, 1'b0);
        chk(if_err == 0, "R3 no error within count", int'(if_err), 0);
        put(2'd1, 8'd3, 8'h33, 1'b1);
        chk(if_err == 1, "R3 error on overrun", int'(if_err), 1);
        put(2'd2, 8'd0, 8'd7, 1'b1);
        chk(send_req == 1 && int'(send_len) == 2, "R3 overrun byte dropped", int'(send_len), 2);

        // R11: store full
        put(2'd1, 8'd0, 8'd255, 1'b0);
        for (int i = 0; i < DEPTH; i++) put(2'd1, 8'(i + 1), 8'(i), 1'b0);
        chk(if_err == 0, "R11 no error up to capacity", int'(if_err), 0);
        put(2'd1, 8'(DEPTH + 1), 8'hEE, 1'b1);
        chk(if_err == 1, "R11 error beyond capacity", int'(if_err), 1);
        put(2'd2, 8'd0, 8'd0, 1'b1);
        chk(int'(send_len) == DEPTH && send_req == 1, "R11 length stays at capacity",
            int'(send_len), DEPTH);

        // R9: flush command vs unrelated command
        load(3, 5);
        put(2'd3, 8'd0, 8'h42, 1'b1);
        put(2'd2, 8'd0, 8'd7, 1'b1);
        chk(send_req == 1 && int'(send_len) == 3, "R9 other command keeps index",
            int'(send_len), 3);
        load(3, 6);
        put(2'd3, 8'd0, FLUSH, 1'b1);
        put(2'd2, 8'd0, 8'd7, 1'b1);
        chk(send_req == 1 && int'(send_len) == 0, "R9 flush zeroes index", int'(send_len), 0);

        // R10: two-byte transmit access
        load(4, 9);
        put(2'd2, 8'd0, 8'd0, 1'b0);
        put(2'd2, 8'd1, 8'd0, 1'b1);
        chk(if_err == 1 && send_req == 0, "R10 multi-byte transmit rejected",
            int'({if_err, send_req}), 2);
        put(2'd2, 8'd0, 8'd1, 1'b1);
        chk(send_req == 1 && int'(send_len) == 4, "R10 index unchanged after reject",
            int'(send_len), 4);

        // R6: status mapping, stickiness, clear, set-over-clear
        stat(2'd3, 3'b111);
        for (int c = 0; c < 4; c++) begin
            stat(2'(c), 3'b000);
            flags_v = (c < 3) ? (1 << c) : 0;
            chk(int'({alert_fail, alert_disc, alert_ok}) == flags_v, "R6 status mapping",
                int'({alert_fail, alert_disc, alert_ok}), flags_v);
            idle();
            chk(int'({alert_fail, alert_disc, alert_ok}) == flags_v, "R6 flag sticky",
                int'({alert_fail, alert_disc, alert_ok}), flags_v);
            stat(2'd3, 3'b111);
            chk({alert_fail, alert_disc, alert_ok} == 3'b000, "R6 clear",
                int'({alert_fail, alert_disc, alert_ok}), 0);
        end
        stat(2'd1, 3'b010);
        chk(alert_disc == 1, "R6 set wins over clear", int'(alert_disc), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog expired act=%0d exp=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule